// File: doc/BRIEF.md
# Timer Pin GPIO and Capture Interrupt Unit

This block owns one external pin and gives it one of two jobs, picked by a three-bit function code in a 32-bit control word. As a general-purpose I/O, software sets the pad's output enable and level through two control bits. As a capture source, the block watches the synchronized pin for a rising edge, a falling edge or both, latches an event flag and raises a single interrupt line when that is enabled. The codes for compare output and PWM are stored but do nothing here.

Software reaches the block through a word-addressed register port with a single-cycle write strobe and a combinational read. Word 0 is the control word. Word 1 is the status word: an event flag that is cleared by writing one to it, and a live copy of the synchronized pin level. The asynchronous active-low reset is released in step with the clock inside the block.

Top module: `tpc_unit`

## Requirements
- R1: The control word at address 0 stores all 32 written bits and reads them back unchanged; reset clears it to zero.
- R2: The pad output enable is high only when control bits [2:0] equal 4 and control bit 5 is set. The pad output level always equals control bit 4, so [5:4] = 00 leaves the pin as an input, 10 drives low and 11 drives high.
- R3: The interrupt output is high exactly when control bit 8 is set and status bit 0 is set. With bit 8 clear, events still set status bit 0.
- R4: With control bits [2:0] equal to 1, control bits [17:16] pick the capture edge: 01 rising, 10 falling, 11 both, 00 none.
- R5: Writing address 1 with data bit 0 set clears status bit 0; writing 0 there leaves it unchanged. Status bits [7:1] and [31:9] read as zero.
- R6: Status bit 8 reads the pin level two clock edges after it is applied at the pin, in every function code.
- R7: With function code 1, the output enable stays low whatever control bits [5:4] hold.
- R8: A qualifying pin edge sets status bit 0 on the third clock edge after the pin changes.
- R9: After reset the status word reads zero except bit 8, the interrupt is low and the output enable is low.
- R10: When an event and a clearing write meet in the same cycle, status bit 0 ends set.
- R11: Function codes other than 1 and 4 (such as 2 and 3) set no status flag and leave the output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Word address: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| pin_in | input | 1 | Pin level from the pad |
| pin_oe | output | 1 | Pad output enable |
| pin_out | output | 1 | Pad output level |
| irq | output | 1 | Interrupt request |

## Verification
A control write lands on the next clock edge, after which read data, output enable, pad level and interrupt change within that cycle, so the bench checks them one cycle after each write. The live pin level in the status word trails the pad by two edges and an event flag by three, and the bench keeps its own three-deep pin history to predict exactly those cycles. Every comparison is made one nanosecond after a falling edge with inputs already settled, and a directed sequence times a clearing write onto the exact cycle an edge is latched.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned WORD_W = 32;

  // function code field
  localparam int unsigned FN_LSB = 0;
  localparam int unsigned FN_W   = 3;
  localparam logic [FN_W-1:0] FN_CAPTURE = 3'd1;
  localparam logic [FN_W-1:0] FN_COMPARE = 3'd2;
  localparam logic [FN_W-1:0] FN_PWM     = 3'd3;
  localparam logic [FN_W-1:0] FN_GPIO    = 3'd4;

  // pad control bits
  localparam int unsigned PAD_LVL_BIT = 4;
  localparam int unsigned PAD_DRV_BIT = 5;

  // interrupt enable
  localparam int unsigned IRQ_EN_BIT = 8;

  // edge select field
  localparam int unsigned EDGE_LSB = 16;
  localparam int unsigned EDGE_W   = 2;

  // status layout
  localparam int unsigned ST_FLAG_BIT = 0;
  localparam int unsigned ST_PIN_BIT  = 8;

  typedef enum logic {
    REG_CTRL   = 1'b0,
    REG_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tpc_rst_sync.sv
module tpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tpc_pin_sync.sv
module tpc_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stage_d;
    if (i == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_next
      assign stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/tpc_edge_det.sv
module tpc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_comb begin
    rise = level & ~prev_q;
    fall = ~level & prev_q;
  end

  assert_edge_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
  assert_rise_prev_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> prev_q);
endmodule

// File: rtl/tpc_unit.sv
module tpc_unit #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        pin_in,
  output logic        pin_oe,
  output logic        pin_out,
  output logic        irq
);
  import tpc_pkg::*;

  logic rst_ni;
  logic pin_lvl;
  logic pin_rise;
  logic pin_fall;

  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic              flag_q, flag_d;
  logic              ctrl_we;
  logic              flag_clr;
  logic              cap_on;
  logic              cap_event;
  logic [FN_W-1:0]   fn_code;
  logic [EDGE_W-1:0] edge_sel;

  tpc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  tpc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_ni),
    .async_in (pin_in),
    .sync_out (pin_lvl)
  );

  tpc_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_ni),
    .level (pin_lvl),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  // field decode
  always_comb begin
    fn_code   = ctrl_q[FN_LSB +: FN_W];
    edge_sel  = ctrl_q[EDGE_LSB +: EDGE_W];
    cap_on    = (fn_code == FN_CAPTURE) && (edge_sel != '0);
    cap_event = cap_on && ((edge_sel[0] && pin_rise) || (edge_sel[1] && pin_fall));
  end

  // next state
  always_comb begin
    ctrl_we  = wr_en && (addr == REG_CTRL);
    flag_clr = wr_en && (addr == REG_STATUS) && wr_data[ST_FLAG_BIT];
    ctrl_d   = ctrl_q;
    if (ctrl_we) ctrl_d = wr_data;
    flag_d   = (flag_q && !flag_clr) || cap_event;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  // outputs
  always_comb begin
    pin_oe  = (fn_code == FN_GPIO) && ctrl_q[PAD_DRV_BIT];
    pin_out = ctrl_q[PAD_LVL_BIT];
    irq     = ctrl_q[IRQ_EN_BIT] && flag_q;
    rd_data = '0;
    if (addr == REG_CTRL) begin
      rd_data = ctrl_q;
    end else begin
      rd_data[ST_FLAG_BIT] = flag_q;
      rd_data[ST_PIN_BIT]  = pin_lvl;
    end
  end

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    cap_event |=> flag_q);
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_clr && !cap_event) |=> !flag_q);
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!flag_clr && !cap_event) |=> $stable(flag_q));
  assert_oe_gpio_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    pin_oe |-> (ctrl_q[FN_LSB +: FN_W] == FN_GPIO));
  assert_cap_input_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[FN_LSB +: FN_W] == FN_CAPTURE) |-> !pin_oe);
  assert_irq_flag_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> rd_data[31:0] == rd_data[31:0] && flag_q && ctrl_q[IRQ_EN_BIT]);
  assert_no_event_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[FN_LSB +: FN_W] != FN_CAPTURE) |-> !cap_event);
endmodule

// File: tb/sim_tpc_unit.sv
module sim_tpc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        pin_in;
  logic        pin_oe;
  logic        pin_out;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench reference state
  logic [31:0] m_ctrl;
  logic        m_flag;
  logic        h1, h2, h3;

  always #4 clk = ~clk;

  tpc_unit u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_oe  (pin_oe),
    .pin_out (pin_out),
    .irq     (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic a);
    logic [31:0] v;
    if (a == 1'b0) v = m_ctrl;
    else begin
      v = '0;
      v[0] = m_flag;
      v[8] = h2;
    end
    return v;
  endfunction

  function automatic logic exp_event();
    logic [1:0] es;
    es = m_ctrl[17:16];
    if (m_ctrl[2:0] != 3'd1) return 1'b0;
    return (es[0] && h2 && !h3) || (es[1] && !h2 && h3);
  endfunction

  task automatic step(input logic w, input logic a, input logic [31:0] d, input logic p);
    logic ev;
    wr_en = w; addr = a; wr_data = d; pin_in = p;
    #1;
    if (a) chk("R5 R6 R8 R10 status", rd_data, exp_rd(a));
    else   chk("R1 control", rd_data, exp_rd(a));
    chk("R3 irq", {31'b0, irq}, {31'b0, m_ctrl[8] & m_flag});
    chk("R2 R7 R11 oe", {31'b0, pin_oe}, {31'b0, (m_ctrl[2:0] == 3'd4) & m_ctrl[5]});
    chk("R2 level", {31'b0, pin_out}, {31'b0, m_ctrl[4]});
    @(posedge clk);
    ev = exp_event();
    m_flag = (m_flag & ~(w & a & d[0])) | ev;
    h3 = h2; h2 = h1; h1 = p;
    if (w && !a) m_ctrl = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic p, input logic a);
    for (int i = 0; i < n; i++) step(1'b0, a, 32'h0, p);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5));
    rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wr_data = '0; pin_in = 1'b0;
    m_ctrl = '0; m_flag = 1'b0; h1 = 1'b0; h2 = 1'b0; h3 = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    addr = 1'b0; #1;
    chk("R9 control after reset", rd_data, 32'h0);
    addr = 1'b1; #1;
    chk("R9 status after reset", rd_data, 32'h0);
    chk("R9 irq after reset", {31'b0, irq}, 32'h0);
    chk("R9 oe after reset", {31'b0, pin_oe}, 32'h0);

    // R1 full readback
    step(1'b1, 1'b0, 32'hA5C3_0E5A, 1'b0);
    step(1'b0, 1'b0, 32'h0, 1'b0);

    // R2 GPIO drive high, low, input
    step(1'b1, 1'b0, 32'h0000_0034, 1'b0);
    idle(3, 1'b1, 1'b1);
    step(1'b1, 1'b0, 32'h0000_0024, 1'b1);
    step(1'b1, 1'b0, 32'h0000_0004, 1'b1);
    idle(2, 1'b0, 1'b1);

    // R7 capture with drive bits set; R4 rising, irq disabled (R3)
    step(1'b1, 1'b0, 32'h0001_0031, 1'b0);
    idle(3, 1'b0, 1'b1);
    idle(4, 1'b1, 1'b1);
    step(1'b1, 1'b1, 32'h1, 1'b1);
    idle(4, 1'b0, 1'b1);
    // R4 falling with irq enabled
    step(1'b1, 1'b0, 32'h0002_0101, 1'b1);
    idle(4, 1'b1, 1'b1);
    idle(4, 1'b0, 1'b1);
    // R5 write zero keeps flag, write one clears
    step(1'b1, 1'b1, 32'hFFFF_FFFE, 1'b0);
    step(1'b1, 1'b1, 32'h1, 1'b0);
    idle(2, 1'b0, 1'b1);
    // R4 edge select 00 detects nothing
    step(1'b1, 1'b0, 32'h0000_0101, 1'b0);
    idle(4, 1'b1, 1'b1);
    idle(4, 1'b0, 1'b1);
    // R11 compare and pwm codes inert
    step(1'b1, 1'b0, 32'h0003_0132, 1'b0);
    idle(4, 1'b1, 1'b1);
    step(1'b1, 1'b0, 32'h0003_0133, 1'b1);
    idle(4, 1'b0, 1'b1);

    // R10 collision: edge latched in the same cycle as a clear
    step(1'b1, 1'b0, 32'h0003_0101, 1'b0);
    idle(3, 1'b0, 1'b1);
    step(1'b0, 1'b1, 32'h0, 1'b1);
    step(1'b0, 1'b1, 32'h0, 1'b1);
    step(1'b1, 1'b1, 32'h1, 1'b1);
    addr = 1'b1; wr_en = 1'b0; #1;
    chk("R10 flag kept after collision", {31'b0, rd_data[0]}, 32'h1);
    @(negedge clk);
    step(1'b1, 1'b1, 32'h1, 1'b1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic w, a, p;
      int r;
      r = $urandom_range(0, 15);
      p = ($urandom_range(0, 3) == 0) ? ~h1 : h1;
      w = (r < 2);
      a = $urandom_range(0, 1);
      d = $urandom;
      if (w && !a) begin
        d[2:0] = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7))
                 : (($urandom_range(0, 1) == 0) ? 3'd1 : 3'd4);
      end
      if (w && a && $urandom_range(0, 1) == 0) d[0] = 1'b0;
      step(w, a, d, p);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule